// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt File

This block holds the byte-wide registers of a small SCSI bus controller. It has sixteen register slots. Each slot has two separate copies: one the host writes and one the host reads. A host bus reaches the slots through a byte address. The address is shifted right by a build-time amount, so the registers can sit on a word-aligned map. A command engine and a data path sit beside the block. They read the host-written copy through a private read port. They update the status, interrupt, sequence-step and flags registers through set, clear and load pins.

The status register bit 7 is the pending-interrupt flag, and the single active-high interrupt pin follows it. When the host reads the interrupt register, it gets the value held before the read. In the same access the block acknowledges the interrupt: it empties that register, clears the terminal-count and pending bits of the status register, forces the sequence step to 4 and drops the interrupt pin. A synchronous hard reset and a one-cycle soft reset from the command engine both bring every register back to its known start value.

All pins are plain control and status signals. A register access finishes in the cycle it is presented, so there is no handshake and no back-pressure at either edge.

Top module: `scsi_regfile`

## Requirements
- R1: The register slot is bus address bits [ADDR_SHIFT+3:ADDR_SHIFT]. The lower ADDR_SHIFT bits do not affect which slot is read or written. With the default ADDR_SHIFT of 2, the slot is bits 5:2.
- R2: After a hard reset every read-side slot is 0, except slot 8, which reads 0x07, and slot 14, which reads 0x04. Every write-side slot is 0, and irq is low.
- R3: A one-cycle pulse on eng_soft_rst drops irq and restores every register to the R2 values. Hard reset and soft reset take priority over every other update in that cycle.
- R4: A host write to slot 8 or to slots 11 to 15 updates both the read-side copy and the write-side copy of that slot. The read side shows the new value from the next cycle.
- R5: A host write to slots 0 to 7, 9 or 10 updates only the write-side copy (seen on eng_rdata). The read-side value of that slot stays unchanged.
- R6: irq always equals status (slot 4) bit 7. eng_raise sets that bit and eng_lower clears it. Raising or lowering a bit that already has that value changes nothing. When both are asserted in one cycle, eng_raise wins.
- R7: bus_rdata shows the read-side value of the addressed slot in the same cycle. A read of slot 5 therefore returns the value held before that read's side effects.
- R8: At the clock edge of a read of slot 5, slot 5 becomes 0, status bits 7 and 4 are cleared while status bits 6:5 and 3:0 are kept, slot 6 becomes 0x04, and irq falls.
- R9: The R8 side effects happen once per read strobe, on the first cycle of a high period of bus_rd. Holding bus_rd high on slot 5 for further cycles does not repeat them.
- R10: eng_stat_set and eng_stat_clr change status bits 6:0 as new = (old & ~clr) | set, and leave bit 7 alone. In a cycle that also acknowledges slot 5, the engine updates are applied after the R8 side effects.
- R11: eng_intr_set is ORed into slot 5. eng_seq_we loads eng_seq_val into slot 6, and eng_flags_we loads eng_flags_val into slot 7.
- R12: Reads of any slot other than 5 have no side effect on any register or on irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high hard reset |
| bus_addr | input | 4+ADDR_SHIFT | Host byte address |
| bus_rd | input | 1 | Host read strobe (level; its first cycle triggers side effects) |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read-side value of the addressed slot |
| eng_raddr | input | 4 | Slot selected on the engine view of the write side |
| eng_rdata | output | 8 | Write-side value of slot eng_raddr |
| eng_stat_set | input | 8 | Status bits to set (bits 6:0 used) |
| eng_stat_clr | input | 8 | Status bits to clear (bits 6:0 used) |
| eng_intr_set | input | 8 | Cause bits ORed into the interrupt register |
| eng_seq_we | input | 1 | Load the sequence-step register |
| eng_seq_val | input | 8 | Sequence-step value |
| eng_flags_we | input | 1 | Load the flags register |
| eng_flags_val | input | 8 | Flags value |
| eng_raise | input | 1 | Set the pending-interrupt flag |
| eng_lower | input | 1 | Clear the pending-interrupt flag |
| eng_soft_rst | input | 1 | One-cycle soft reset request |
| irq | output | 1 | Active-high interrupt, copy of status bit 7 |

## Verification
The bench first sweeps all sixteen slots under all four low-address offsets, writing a value that is different for each slot and offset. This separates mirrored slots from write-only slots and shows that the low address bits are ignored. Status set and clear masks with bit 7 present in them show that only the raise and lower pins move the flag. The bench then runs acknowledge reads three ways: single-cycle, held for several cycles with engine updates in the middle, and in the same cycle as an engine raise. These cases separate a read that acts once from one that acts every cycle, and show which update wins at a shared edge. A soft reset after dirtying every kind of slot shows that it restores the same values as the hard reset.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;
  localparam int RF_DW   = 8;
  localparam int RF_NREG = 16;
  localparam int RF_IW   = $clog2(RF_NREG);

  typedef logic [RF_DW-1:0] rf_byte_t;

  // slot numbers that carry behaviour
  localparam int SLOT_STAT    = 4;
  localparam int SLOT_INTR    = 5;
  localparam int SLOT_SEQ     = 6;
  localparam int SLOT_FLAGS   = 7;
  localparam int SLOT_CFG1    = 8;
  localparam int SLOT_VARIANT = 14;

  localparam int STAT_PEND_BIT = 7;
  localparam int STAT_TC_BIT   = 4;
  localparam rf_byte_t STAT_ENG_MASK = 8'h7F;
  localparam rf_byte_t SEQ_ACK_VAL   = 8'h04;
  localparam rf_byte_t CFG1_INIT     = 8'h07;
  localparam rf_byte_t VARIANT_INIT  = 8'h04;

  function automatic logic rf_mirrored(input int slot);
    return (slot == SLOT_CFG1) || (slot >= 11 && slot < RF_NREG);
  endfunction

  function automatic rf_byte_t rf_read_init(input int slot);
    if (slot == SLOT_CFG1)    return CFG1_INIT;
    if (slot == SLOT_VARIANT) return VARIANT_INIT;
    return '0;
  endfunction
endpackage

// File: rtl/rf_bus_dec.sv
module rf_bus_dec
  import scsi_rf_pkg::*;
#(
  parameter int SHIFT = 2,
  localparam int AW = RF_IW + SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_rd,
  output logic [RF_IW-1:0] slot,
  output logic             rd_first
);
  logic rd_q;

  assign slot = bus_addr[SHIFT +: RF_IW];

  generate
    if (SHIFT > 0) begin : g_low
      logic unused_low_bits;
      assign unused_low_bits = ^bus_addr[SHIFT-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= bus_rd;
  end

  // side effects fire only on the opening cycle of a read
  assign rd_first = bus_rd & ~rd_q;
endmodule

// File: rtl/rf_wside.sv
module rf_wside
  import scsi_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             wr,
  input  logic [RF_IW-1:0] slot,
  input  rf_byte_t         wdata,
  input  logic [RF_IW-1:0] eng_raddr,
  output rf_byte_t         eng_rdata
);
  logic [RF_NREG-1:0][RF_DW-1:0] wq;

  for (genvar g = 0; g < RF_NREG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || soft_rst)
        wq[g] <= '0;
      else if (wr && slot == RF_IW'(g))
        wq[g] <= wdata;
    end
  end

  assign eng_rdata = wq[eng_raddr];
endmodule

// File: rtl/rf_rside.sv
module rf_rside
  import scsi_rf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          soft_rst,
  input  logic                          wr,
  input  logic [RF_IW-1:0]              slot,
  input  rf_byte_t                      wdata,
  input  logic                          ack,
  input  rf_byte_t                      stat_set,
  input  rf_byte_t                      stat_clr,
  input  rf_byte_t                      intr_set,
  input  logic                          seq_we,
  input  rf_byte_t                      seq_val,
  input  logic                          flags_we,
  input  rf_byte_t                      flags_val,
  input  logic                          raise,
  input  logic                          lower,
  output logic [RF_NREG-1:0][RF_DW-1:0] rside,
  output logic                          irq
);
  for (genvar g = 0; g < RF_NREG; g++) begin : g_slot
    rf_byte_t q;
    rf_byte_t d;

    if (g == SLOT_STAT) begin : g_stat
      always_comb begin
        d = q;
        if (ack) begin
          d[STAT_PEND_BIT] = 1'b0;
          d[STAT_TC_BIT]   = 1'b0;
        end
        d = (d & ~(stat_clr & STAT_ENG_MASK)) | (stat_set & STAT_ENG_MASK);
        if (lower) d[STAT_PEND_BIT] = 1'b0;
        if (raise) d[STAT_PEND_BIT] = 1'b1;
      end
    end else if (g == SLOT_INTR) begin : g_intr
      always_comb begin
        d = ack ? '0 : q;
        d = d | intr_set;
      end
    end else if (g == SLOT_SEQ) begin : g_seq
      always_comb begin
        d = ack ? SEQ_ACK_VAL : q;
        if (seq_we) d = seq_val;
      end
    end else if (g == SLOT_FLAGS) begin : g_flags
      assign d = flags_we ? flags_val : q;
    end else if (rf_mirrored(g)) begin : g_mirror
      assign d = (wr && slot == RF_IW'(g)) ? wdata : q;
    end else begin : g_hold
      assign d = q;
    end

    always_ff @(posedge clk) begin
      if (rst || soft_rst) q <= rf_read_init(g);
      else                 q <= d;
    end

    assign rside[g] = q;
  end

  assign irq = rside[SLOT_STAT][STAT_PEND_BIT];
endmodule

// File: rtl/scsi_regfile.sv
module scsi_regfile
  import scsi_rf_pkg::*;
#(
  parameter int ADDR_SHIFT = 2,
  localparam int BUS_AW = RF_IW + ADDR_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [3:0]        eng_raddr,
  output logic [7:0]        eng_rdata,
  input  logic [7:0]        eng_stat_set,
  input  logic [7:0]        eng_stat_clr,
  input  logic [7:0]        eng_intr_set,
  input  logic              eng_seq_we,
  input  logic [7:0]        eng_seq_val,
  input  logic              eng_flags_we,
  input  logic [7:0]        eng_flags_val,
  input  logic              eng_raise,
  input  logic              eng_lower,
  input  logic              eng_soft_rst,
  output logic              irq
);
  logic [RF_IW-1:0]              reg_slot;
  logic                          rd_first;
  logic                          ack;
  logic [RF_NREG-1:0][RF_DW-1:0] rside_q;

  rf_bus_dec #(.SHIFT(ADDR_SHIFT)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .slot     (reg_slot),
    .rd_first (rd_first)
  );

  assign ack = rd_first && (reg_slot == RF_IW'(SLOT_INTR));

  rf_wside u_wside (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (eng_soft_rst),
    .wr        (bus_wr),
    .slot      (reg_slot),
    .wdata     (bus_wdata),
    .eng_raddr (eng_raddr),
    .eng_rdata (eng_rdata)
  );

  rf_rside u_rside (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (eng_soft_rst),
    .wr        (bus_wr),
    .slot      (reg_slot),
    .wdata     (bus_wdata),
    .ack       (ack),
    .stat_set  (eng_stat_set),
    .stat_clr  (eng_stat_clr),
    .intr_set  (eng_intr_set),
    .seq_we    (eng_seq_we),
    .seq_val   (eng_seq_val),
    .flags_we  (eng_flags_we),
    .flags_val (eng_flags_val),
    .raise     (eng_raise),
    .lower     (eng_lower),
    .rside     (rside_q),
    .irq       (irq)
  );

  assign bus_rdata = rside_q[reg_slot];
endmodule

// File: rtl/scsi_regfile_chk.sv
module scsi_regfile_chk
  import scsi_rf_pkg::*;
(
  input logic                          clk,
  input logic                          rst,
  input logic                          soft_rst,
  input logic                          bus_wr,
  input logic [7:0]                    bus_wdata,
  input logic [RF_IW-1:0]              slot,
  input logic                          rd_first,
  input logic                          raise,
  input logic                          lower,
  input logic [7:0]                    intr_set,
  input logic                          seq_we,
  input logic                          irq,
  input logic [RF_NREG-1:0][RF_DW-1:0] rside
);
  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (raise && !soft_rst) |=> irq);

  // R6
  irq_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (lower && !raise && !soft_rst) |=> !irq);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_first && slot == RF_IW'(SLOT_INTR) && !raise && !soft_rst)
      |=> (!irq && rside[SLOT_INTR] == $past(intr_set)));

  // R8
  ack_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_first && slot == RF_IW'(SLOT_INTR) && !seq_we && !soft_rst)
      |=> rside[SLOT_SEQ] == SEQ_ACK_VAL);

  // R4
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && rf_mirrored(int'(slot)) && !soft_rst)
      |=> rside[$past(slot)] == $past(bus_wdata));

  // R3
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!irq && rside[SLOT_CFG1] == CFG1_INIT
                  && rside[SLOT_VARIANT] == VARIANT_INIT
                  && rside[SLOT_INTR] == '0));
endmodule

bind scsi_regfile scsi_regfile_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .soft_rst  (eng_soft_rst),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .slot      (reg_slot),
  .rd_first  (rd_first),
  .raise     (eng_raise),
  .lower     (eng_lower),
  .intr_set  (eng_intr_set),
  .seq_we    (eng_seq_we),
  .irq       (irq),
  .rside     (rside_q)
);

// File: tb/test_scsi_regfile.sv
module test_scsi_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] eng_raddr;
  logic [7:0] eng_rdata;
  logic [7:0] eng_stat_set, eng_stat_clr, eng_intr_set, eng_seq_val, eng_flags_val;
  logic       eng_seq_we, eng_flags_we, eng_raise, eng_lower, eng_soft_rst;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_r [16];
  logic [7:0] exp_w [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regfile i_scsi_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_raddr(eng_raddr),
    .eng_rdata(eng_rdata), .eng_stat_set(eng_stat_set), .eng_stat_clr(eng_stat_clr),
    .eng_intr_set(eng_intr_set), .eng_seq_we(eng_seq_we), .eng_seq_val(eng_seq_val),
    .eng_flags_we(eng_flags_we), .eng_flags_val(eng_flags_val), .eng_raise(eng_raise),
    .eng_lower(eng_lower), .eng_soft_rst(eng_soft_rst), .irq(irq)
  );

  function automatic logic is_mirror(input int s);
    return (s == 8) || (s >= 11);
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 16; s++) begin
      exp_r[s] = 8'h00;
      exp_w[s] = 8'h00;
    end
    exp_r[8]  = 8'h07;
    exp_r[14] = 8'h04;
  endtask

  task automatic model_ack();
    exp_r[5]    = 8'h00;
    exp_r[4][7] = 1'b0;
    exp_r[4][4] = 1'b0;
    exp_r[6]    = 8'h04;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic irq_chk(input string tag);
    chk(tag, {7'b0, irq}, {7'b0, exp_r[4][7]});
  endtask

  task automatic rd_chk(input int s, input int lo, input string tag);
    @(negedge clk);
    bus_addr = {4'(s), 2'(lo)};
    bus_rd   = 1'b1;
    #1;
    chk(tag, bus_rdata, exp_r[s]);
    @(negedge clk);
    bus_rd = 1'b0;
    if (s == 5) model_ack();
  endtask

  task automatic wr(input int s, input int lo, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = {4'(s), 2'(lo)};
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    exp_w[s] = d;
    if (is_mirror(s)) exp_r[s] = d;
  endtask

  task automatic wchk(input int s, input string tag);
    eng_raddr = 4'(s);
    #1;
    chk(tag, eng_rdata, exp_w[s]);
  endtask

  task automatic eng(input logic [7:0] st_s, input logic [7:0] st_c, input logic [7:0] it,
                     input logic swe, input logic [7:0] sv, input logic fwe,
                     input logic [7:0] fv, input logic ra, input logic lo);
    @(negedge clk);
    eng_stat_set = st_s; eng_stat_clr = st_c; eng_intr_set = it;
    eng_seq_we = swe; eng_seq_val = sv; eng_flags_we = fwe; eng_flags_val = fv;
    eng_raise = ra; eng_lower = lo;
    @(negedge clk);
    eng_stat_set = 8'h00; eng_stat_clr = 8'h00; eng_intr_set = 8'h00;
    eng_seq_we = 1'b0; eng_flags_we = 1'b0; eng_raise = 1'b0; eng_lower = 1'b0;
    exp_r[4] = (exp_r[4] & ~(st_c & 8'h7F)) | (st_s & 8'h7F);
    if (lo) exp_r[4][7] = 1'b0;
    if (ra) exp_r[4][7] = 1'b1;
    exp_r[5] = exp_r[5] | it;
    if (swe) exp_r[6] = sv;
    if (fwe) exp_r[7] = fv;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles, expected completion sooner", WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    eng_raddr = '0; eng_stat_set = '0; eng_stat_clr = '0; eng_intr_set = '0;
    eng_seq_we = 1'b0; eng_seq_val = '0; eng_flags_we = 1'b0; eng_flags_val = '0;
    eng_raise = 1'b0; eng_lower = 1'b0; eng_soft_rst = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();

    // R2: reset state of both copies and the interrupt pin
    irq_chk("R2 irq");
    for (int s = 0; s < 16; s++) rd_chk(s, s % 4, "R2 read side");
    for (int s = 0; s < 16; s++) wchk(s, "R2 write side");

    // R1 R4 R5: every slot under every low-address offset
    for (int s = 0; s < 16; s++) begin
      for (int lo = 0; lo < 4; lo++) begin
        wr(s, lo, 8'(s * 37 + lo * 11 + 5));
        rd_chk(s, (lo + 1) % 4, is_mirror(s) ? "R1 R4 mirrored" : "R1 R5 write-only");
        wchk(s, "R4 R5 write side");
      end
    end

    // R6: raise, repeated raise, lower, repeated lower, both together
    eng(8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    irq_chk("R6 raise");
    eng(8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    irq_chk("R6 raise again");
    eng(8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    irq_chk("R6 lower");
    eng(8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    irq_chk("R6 lower again");
    eng(8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1);
    irq_chk("R6 raise wins");
    rd_chk(4, 2, "R6 status bit 7");

    // R10: status set/clear masks, bit 7 untouched
    for (int k = 0; k < 6; k++) begin
      eng(8'(k * 53 + 8'h81), 8'(k * 29 + 8'h8F), 8'h00, 1'b0, 8'h00, 1'b0, 8'h00,
          1'b0, 1'b0);
      rd_chk(4, k % 4, "R10 status mask");
      irq_chk("R10 bit 7 kept");
    end

    // R11: engine loads
    eng(8'h00, 8'h00, 8'h08, 1'b1, 8'h03, 1'b0, 8'h00, 1'b0, 1'b0);
    eng(8'h00, 8'h00, 8'h10, 1'b0, 8'h00, 1'b1, 8'h2A, 1'b0, 1'b0);
    rd_chk(6, 0, "R11 seq load");
    rd_chk(7, 1, "R11 flags load");
    rd_chk(5, 2, "R11 R7 intr or");

    // R7 R8: acknowledge read
    eng(8'h17, 8'h7F, 8'h20, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    irq_chk("R8 pending before");
    rd_chk(5, 0, "R7 old value");
    irq_chk("R8 irq dropped");
    rd_chk(4, 1, "R8 status after ack");
    rd_chk(6, 2, "R8 seq forced");
    rd_chk(5, 3, "R8 intr emptied");

    // R12: reads of other slots do nothing
    eng(8'h30, 8'h00, 8'h00, 1'b1, 8'h02, 1'b0, 8'h00, 1'b1, 1'b0);
    for (int s = 0; s < 16; s++)
      if (s != 5) rd_chk(s, 3, "R12 no side effect");
    irq_chk("R12 irq kept");
    rd_chk(6, 0, "R12 seq kept");

    // R9: held read acts only once
    eng(8'h00, 8'h00, 8'h20, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    @(negedge clk);
    bus_addr = {4'd5, 2'd1};
    bus_rd   = 1'b1;
    #1;
    chk("R9 first cycle", bus_rdata, exp_r[5]);
    model_ack();
    @(negedge clk);
    eng_raise = 1'b1; eng_seq_we = 1'b1; eng_seq_val = 8'h02; eng_intr_set = 8'h08;
    @(negedge clk);
    eng_raise = 1'b0; eng_seq_we = 1'b0; eng_intr_set = 8'h00;
    exp_r[4][7] = 1'b1; exp_r[6] = 8'h02; exp_r[5] = 8'h08;
    @(negedge clk);
    bus_rd = 1'b0;
    irq_chk("R9 raise survives hold");
    rd_chk(6, 2, "R9 seq survives hold");
    rd_chk(5, 0, "R9 intr survives hold");

    // R10: engine update after ack in the same cycle
    @(negedge clk);
    bus_addr = {4'd5, 2'd2};
    bus_rd = 1'b1; eng_raise = 1'b1; eng_stat_set = 8'h10;
    @(negedge clk);
    bus_rd = 1'b0; eng_raise = 1'b0; eng_stat_set = 8'h00;
    model_ack();
    exp_r[4] = exp_r[4] | 8'h90;
    irq_chk("R10 raise after ack");
    rd_chk(4, 3, "R10 set after ack");

    // R3: soft reset
    wr(8, 0, 8'h55);
    wr(12, 1, 8'hC3);
    wr(2, 2, 8'h99);
    eng(8'h05, 8'h00, 8'h80, 1'b1, 8'h07, 1'b1, 8'h11, 1'b1, 1'b0);
    irq_chk("R3 pending before soft reset");
    @(negedge clk);
    eng_soft_rst = 1'b1;
    @(negedge clk);
    eng_soft_rst = 1'b0;
    model_reset();
    irq_chk("R3 irq after soft reset");
    for (int s = 0; s < 16; s++) rd_chk(s, 1, "R3 read side");
    for (int s = 0; s < 16; s++) wchk(s, "R3 write side");

    summary();
    $finish;
  end
endmodule